// File: doc/BRIEF.md
# Auxiliary-Channel Request Dispatcher with I2C Bridge

This block serves one decoded auxiliary-channel request at a time and answers it with a reply code. A request carries a 4-bit command, a 20-bit address, a length of 1 to 16 bytes and a packed write buffer. Native commands walk a 1 MiB byte-wide register space, one access per byte at rising addresses. I2C commands drive a byte-level I2C master through start, byte-transfer and stop operations.

The middle-of-transaction variants of the I2C commands leave the I2C transaction open after a clean data phase. The block records the address and command of the last middle-of-transaction request that started or continued. A later request with the same address and command then carries on without a new start condition. A request with a different address or command stops the open transaction and issues a fresh start.

Read data returns in the reply buffer at the byte positions used for write data. A new request is taken only after the reply has been consumed.

Top module: `aux_i2c_bridge`

## Requirements
- R1: Command codes are 0x8 native write, 0x9 native read, 0x0 I2C write, 0x1 I2C read, 0x4 I2C write that stays open, and 0x5 I2C read that stays open; bit 0 set means read. Any other code is answered with NACK and causes no register access and no I2C operation.
- R2: Reply codes are 00 ACK, 01 NACK and 10 I2C NACK. `reqReady` is high only while the block is idle, so no request is accepted from acceptance until `rspReady` takes the reply. `rspValid` and `rspCode` hold steady until they are taken.
- R3: A native request makes exactly one register access per byte, at the request address plus the byte index, in ascending order and modulo 2^20. Each access holds its address until `regDone`.
- R4: A native request stops at the first access that returns `regErr` and replies NACK; if every access succeeds it replies ACK. Byte i of the read data appears on `rspRdData[8i+7:8i]`.
- R5: A plain I2C request (0x0/0x1) that finds `i2cBusy` high first issues a stop. It then issues a start to the low 7 bits of the request address, reading when command bit 0 is set.
- R6: A start that is not acknowledged ends the request with I2C NACK, with no byte transfer and no stop.
- R7: After an acknowledged plain start, bytes move in order from byte 0, and the first unacknowledged byte ends the data phase. A stop always follows. The reply is ACK only when every byte was acknowledged, otherwise I2C NACK.
- R8: An open-ended request (0x4/0x5) issues a start when `i2cBusy` is low. When `i2cBusy` is high with the same 20-bit address and command as the last open-ended request that succeeded in starting, it skips straight to data. When either differs, it issues a stop and then a start.
- R9: An open-ended request whose bytes are all acknowledged replies ACK and issues no stop. An unacknowledged byte is followed by a stop and an I2C NACK reply.
- R10: A register access or an I2C operation holds its request until its done pulse. A register request and an I2C request are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request taken this cycle when valid |
| reqCmd | input | 4 | Command code |
| reqAddr | input | 20 | Register or I2C address |
| reqLen | input | 5 | Byte count, 1 to 16 |
| reqWrData | input | 128 | Write bytes, byte i at bits 8i+7:8i |
| rspValid | output | 1 | Reply available |
| rspReady | input | 1 | Reply consumed |
| rspCode | output | 2 | Reply code |
| rspRdData | output | 128 | Read bytes, same packing as write data |
| regValid | output | 1 | Register access request |
| regWrite | output | 1 | Access is a write |
| regAddr | output | 20 | Register byte address |
| regWdata | output | 8 | Register write byte |
| regDone | input | 1 | Access complete |
| regErr | input | 1 | Access failed (with regDone) |
| regRdata | input | 8 | Read byte (with regDone) |
| i2cReqValid | output | 1 | I2C operation request |
| i2cOp | output | 2 | 00 start, 01 byte transfer, 10 stop |
| i2cRead | output | 1 | Direction for start and transfer |
| i2cAddr | output | 7 | Target address for start |
| i2cWrByte | output | 8 | Byte to send |
| i2cDone | input | 1 | Operation complete |
| i2cAck | input | 1 | Operation acknowledged (with i2cDone) |
| i2cRdByte | input | 8 | Received byte (with i2cDone) |
| i2cBusy | input | 1 | An I2C transaction is open |

## Verification
The assertions assume that `regDone` and `i2cDone` come only in answer to a pending request, and that `regErr`, `regRdata`, `i2cAck` and `i2cRdByte` are valid in the done cycle. They also assume that `i2cBusy` rises only after an acknowledged start and falls only after a stop, and that `reqLen` lies between 1 and 16. The bench responders raise done exactly one cycle after a request that is not yet answered and keep busy tied to their own start/stop history. Every request uses a length in range. The bench mixes open, continued, restarted and failed transactions so that every branch of the restart decision is visited.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;

  typedef enum logic [1:0] {
    RSP_ACK      = 2'b00,
    RSP_NACK     = 2'b01,
    RSP_I2C_NACK = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    OP_START = 2'b00,
    OP_XFER  = 2'b01,
    OP_STOP  = 2'b10
  } i2c_op_e;

  typedef enum logic [2:0] {
    K_NAT_WR,
    K_NAT_RD,
    K_I2C,
    K_MOT,
    K_BAD
  } kind_e;

  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;

  typedef struct packed {
    logic load;      // capture the incoming request
    logic incCnt;    // advance to the next byte
    logic storeRd;   // write a received byte into the buffer
    logic rdSrcI2c;  // received byte comes from the I2C side
    logic saveMot;   // record address/command of an open transaction
  } strb_t;

endpackage

// File: rtl/aux_bridge_dp.sv
module aux_bridge_dp
  import aux_bridge_pkg::*;
#(
  parameter int AddrW    = 20,
  parameter int MaxLen   = 16,
  parameter int I2cAddrW = 7,
  localparam int LenW    = $clog2(MaxLen + 1),
  localparam int CntW    = $clog2(MaxLen)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strb_t                 strb,
  input  logic [3:0]            reqCmd,
  input  logic [AddrW-1:0]      reqAddr,
  input  logic [LenW-1:0]       reqLen,
  input  logic [MaxLen*8-1:0]   reqWrData,
  input  logic [7:0]            regRdata,
  input  logic [7:0]            i2cRdByte,
  output kind_e                 kind,
  output logic                  isRead,
  output logic                  isLast,
  output logic                  motMatch,
  output logic [AddrW-1:0]      regAddr,
  output logic [7:0]            curByte,
  output logic [I2cAddrW-1:0]   i2cAddr,
  output logic [MaxLen*8-1:0]   rdData
);

  logic [3:0]       cmdQ;
  logic [AddrW-1:0] baseAddr;
  logic [LenW-1:0]  lenQ;
  logic [CntW-1:0]  cnt;
  logic [7:0]       bufMem [MaxLen];

  logic             savedValid;
  logic [AddrW-1:0] savedAddr;
  logic [3:0]       savedCmd;

  // request capture and byte counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= '0;
      baseAddr <= '0;
      lenQ     <= LenW'(1);
      cnt      <= '0;
    end else if (strb.load) begin
      cmdQ     <= reqCmd;
      baseAddr <= reqAddr;
      lenQ     <= reqLen;
      cnt      <= '0;
    end else if (strb.incCnt) begin
      cnt <= cnt + CntW'(1);
    end
  end

  // byte buffer: loaded with write data, overwritten by read bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MaxLen; i++) bufMem[i] <= '0;
    end else if (strb.load) begin
      for (int i = 0; i < MaxLen; i++) bufMem[i] <= reqWrData[i*8 +: 8];
    end else if (strb.storeRd) begin
      bufMem[cnt] <= strb.rdSrcI2c ? i2cRdByte : regRdata;
    end
  end

  // record of the last open-ended transaction that started or continued
  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedValid <= 1'b0;
      savedAddr  <= '0;
      savedCmd   <= '0;
    end else if (strb.saveMot) begin
      savedValid <= 1'b1;
      savedAddr  <= baseAddr;
      savedCmd   <= cmdQ;
    end
  end

  always_comb begin
    unique case (cmdQ)
      CMD_NAT_WR:             kind = K_NAT_WR;
      CMD_NAT_RD:             kind = K_NAT_RD;
      CMD_I2C_WR, CMD_I2C_RD: kind = K_I2C;
      CMD_MOT_WR, CMD_MOT_RD: kind = K_MOT;
      default:                kind = K_BAD;
    endcase
  end

  assign isRead   = cmdQ[0];
  assign isLast   = (LenW'(cnt) + LenW'(1)) >= lenQ;
  assign motMatch = savedValid && (savedAddr == baseAddr) && (savedCmd == cmdQ);
  assign regAddr  = baseAddr + AddrW'(cnt);
  assign curByte  = bufMem[cnt];
  assign i2cAddr  = baseAddr[I2cAddrW-1:0];

  for (genvar g = 0; g < MaxLen; g++) begin : g_rd
    assign rdData[g*8 +: 8] = bufMem[g];
  end

  // R3: the register address moves only on a byte step or a new request
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incCnt && !strb.load) |=> $stable(regAddr));

  // R3: each byte step moves the address up by one
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && !strb.load) |=> (regAddr == AddrW'($past(regAddr) + AddrW'(1))));

endmodule

// File: rtl/aux_bridge_ctrl.sv
module aux_bridge_ctrl
  import aux_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        rspValid,
  input  logic        rspReady,
  output logic [1:0]  rspCode,
  output logic        regValid,
  output logic        regWrite,
  input  logic        regDone,
  input  logic        regErr,
  output logic        i2cReqValid,
  output logic [1:0]  i2cOp,
  output logic        i2cRead,
  input  logic        i2cDone,
  input  logic        i2cAck,
  input  logic        i2cBusy,
  input  kind_e       kind,
  input  logic        isRead,
  input  logic        isLast,
  input  logic        motMatch,
  output strb_t       strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_DISP, S_NAT, S_PRESTOP, S_START, S_XFER, S_STOP, S_REPLY
  } state_e;

  state_e stateQ, stateD;
  rsp_e   codeQ, codeD;
  logic   codeWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      codeQ  <= RSP_ACK;
    end else begin
      stateQ <= stateD;
      if (codeWe) codeQ <= codeD;
    end
  end

  always_comb begin
    stateD = stateQ;
    codeD  = RSP_ACK;
    codeWe = 1'b0;
    strb   = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stateD    = S_DISP;
        end
      end
      S_DISP: begin
        unique case (kind)
          K_NAT_WR, K_NAT_RD: stateD = S_NAT;
          K_I2C:              stateD = i2cBusy ? S_PRESTOP : S_START;
          K_MOT: begin
            if (!i2cBusy) begin
              stateD = S_START;
            end else if (motMatch) begin
              strb.saveMot = 1'b1;
              stateD       = S_XFER;
            end else begin
              stateD = S_PRESTOP;
            end
          end
          default: begin
            codeD  = RSP_NACK;
            codeWe = 1'b1;
            stateD = S_REPLY;
          end
        endcase
      end
      S_NAT: begin
        if (regDone) begin
          if (regErr) begin
            codeD  = RSP_NACK;
            codeWe = 1'b1;
            stateD = S_REPLY;
          end else begin
            strb.storeRd = isRead;
            if (isLast) begin
              codeD  = RSP_ACK;
              codeWe = 1'b1;
              stateD = S_REPLY;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
        end
      end
      S_PRESTOP: begin
        if (i2cDone) stateD = S_START;
      end
      S_START: begin
        if (i2cDone) begin
          if (!i2cAck) begin
            codeD  = RSP_I2C_NACK;
            codeWe = 1'b1;
            stateD = S_REPLY;
          end else begin
            strb.saveMot = (kind == K_MOT);
            stateD       = S_XFER;
          end
        end
      end
      S_XFER: begin
        if (i2cDone) begin
          if (!i2cAck) begin
            codeD  = RSP_I2C_NACK;
            codeWe = 1'b1;
            stateD = S_STOP;
          end else begin
            strb.storeRd  = isRead;
            strb.rdSrcI2c = 1'b1;
            if (isLast) begin
              codeD  = RSP_ACK;
              codeWe = 1'b1;
              stateD = (kind == K_MOT) ? S_REPLY : S_STOP;
            end else begin
              strb.incCnt = 1'b1;
            end
          end
        end
      end
      S_STOP: begin
        if (i2cDone) stateD = S_REPLY;
      end
      S_REPLY: begin
        if (rspReady) stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_comb begin
    i2cReqValid = 1'b1;
    i2cOp       = OP_XFER;
    unique case (stateQ)
      S_PRESTOP, S_STOP: i2cOp = OP_STOP;
      S_START:           i2cOp = OP_START;
      S_XFER:            i2cOp = OP_XFER;
      default:           i2cReqValid = 1'b0;
    endcase
  end

  assign reqReady = (stateQ == S_IDLE);
  assign rspValid = (stateQ == S_REPLY);
  assign rspCode  = codeQ;
  assign regValid = (stateQ == S_NAT);
  assign regWrite = (kind == K_NAT_WR);
  assign i2cRead  = isRead;

  // R2: a pending reply keeps its code until taken
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspCode)));

  // R2: never ready for a new request while a reply waits
  a_r2_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R2: only the three defined reply codes appear
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCode != 2'b11));

  // R1: an unknown command touches neither side
  a_r1_bad_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_DISP && kind == K_BAD) |=> (!regValid && !i2cReqValid && rspValid && rspCode == RSP_NACK));

  // R6: a refused start is followed by no further I2C operation
  a_r6_no_op_after_refusal: assert property (@(posedge clk) disable iff (!rstN)
    (i2cReqValid && i2cOp == OP_START && i2cDone && !i2cAck) |=> !i2cReqValid);

  // R10: an I2C operation is held until done
  a_r10_i2c_hold: assert property (@(posedge clk) disable iff (!rstN)
    (i2cReqValid && !i2cDone) |=> (i2cReqValid && $stable(i2cOp)));

  // R10: a register access is held until done
  a_r10_reg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regDone) |=> regValid);

  // R10: register and I2C sides never requested together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && i2cReqValid));

endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
  import aux_bridge_pkg::*;
#(
  parameter int AddrW    = 20,
  parameter int MaxLen   = 16,
  parameter int I2cAddrW = 7,
  localparam int LenW    = $clog2(MaxLen + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [3:0]           reqCmd,
  input  logic [AddrW-1:0]     reqAddr,
  input  logic [LenW-1:0]      reqLen,
  input  logic [MaxLen*8-1:0]  reqWrData,
  output logic                 rspValid,
  input  logic                 rspReady,
  output logic [1:0]           rspCode,
  output logic [MaxLen*8-1:0]  rspRdData,
  output logic                 regValid,
  output logic                 regWrite,
  output logic [AddrW-1:0]     regAddr,
  output logic [7:0]           regWdata,
  input  logic                 regDone,
  input  logic                 regErr,
  input  logic [7:0]           regRdata,
  output logic                 i2cReqValid,
  output logic [1:0]           i2cOp,
  output logic                 i2cRead,
  output logic [I2cAddrW-1:0]  i2cAddr,
  output logic [7:0]           i2cWrByte,
  input  logic                 i2cDone,
  input  logic                 i2cAck,
  input  logic [7:0]           i2cRdByte,
  input  logic                 i2cBusy
);

  strb_t      strb;
  kind_e      kind;
  logic       isRead;
  logic       isLast;
  logic       motMatch;
  logic [7:0] curByte;

  aux_bridge_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .rspReady   (rspReady),
    .rspCode    (rspCode),
    .regValid   (regValid),
    .regWrite   (regWrite),
    .regDone    (regDone),
    .regErr     (regErr),
    .i2cReqValid(i2cReqValid),
    .i2cOp      (i2cOp),
    .i2cRead    (i2cRead),
    .i2cDone    (i2cDone),
    .i2cAck     (i2cAck),
    .i2cBusy    (i2cBusy),
    .kind       (kind),
    .isRead     (isRead),
    .isLast     (isLast),
    .motMatch   (motMatch),
    .strb       (strb)
  );

  aux_bridge_dp #(
    .AddrW   (AddrW),
    .MaxLen  (MaxLen),
    .I2cAddrW(I2cAddrW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqCmd   (reqCmd),
    .reqAddr  (reqAddr),
    .reqLen   (reqLen),
    .reqWrData(reqWrData),
    .regRdata (regRdata),
    .i2cRdByte(i2cRdByte),
    .kind     (kind),
    .isRead   (isRead),
    .isLast   (isLast),
    .motMatch (motMatch),
    .regAddr  (regAddr),
    .curByte  (curByte),
    .i2cAddr  (i2cAddr),
    .rdData   (rspRdData)
  );

  assign regWdata  = curByte;
  assign i2cWrByte = curByte;

endmodule

// File: tb/tb_aux_i2c_bridge.sv
module tb_aux_i2c_bridge;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqCmd = '0;
  logic [19:0]  reqAddr = '0;
  logic [4:0]   reqLen = 5'd1;
  logic [127:0] reqWrData = '0;
  logic         rspValid;
  logic         rspReady = 1'b0;
  logic [1:0]   rspCode;
  logic [127:0] rspRdData;
  logic         regValid, regWrite;
  logic [19:0]  regAddr;
  logic [7:0]   regWdata;
  logic         regDone = 1'b0, regErr = 1'b0;
  logic [7:0]   regRdata = '0;
  logic         i2cReqValid;
  logic [1:0]   i2cOp;
  logic         i2cRead;
  logic [6:0]   i2cAddr;
  logic [7:0]   i2cWrByte;
  logic         i2cDone = 1'b0, i2cAck = 1'b0, i2cBusy = 1'b0;
  logic [7:0]   i2cRdByte = '0;

  always #5 clk = ~clk;

  aux_i2c_bridge dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspReady(rspReady), .rspCode(rspCode), .rspRdData(rspRdData),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regDone(regDone), .regErr(regErr), .regRdata(regRdata),
    .i2cReqValid(i2cReqValid), .i2cOp(i2cOp), .i2cRead(i2cRead), .i2cAddr(i2cAddr),
    .i2cWrByte(i2cWrByte), .i2cDone(i2cDone), .i2cAck(i2cAck), .i2cRdByte(i2cRdByte),
    .i2cBusy(i2cBusy)
  );

  int testCnt = 0;
  int failCnt = 0;

  function automatic void check(bit ok, string req, longint act, longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endfunction

  // ---- behavioural world: register space and I2C targets ----
  logic [7:0] regMem [int];
  logic [7:0] modelMem [int];
  int regExp[$];
  int i2cExp[$];
  int rspRdCnt = 0;
  logic [6:0] devQ = '0;

  function automatic bit regFault(int a); return a[19:16] == 4'hF; endfunction
  function automatic logic [7:0] memInit(int a); return a[7:0] ^ 8'h5A; endfunction
  function automatic bit devPresent(int a);
    return (a == 'h50) || (a == 'h51) || (a == 'h53);
  endfunction
  function automatic int encReg(bit wr, int a, int d);
    return wr ? ((1 << 28) | (a << 8) | d) : (a << 8);
  endfunction
  function automatic int encI2c(int k, bit rd, int v);
    return k * 65536 + (rd ? 256 : 0) + v;
  endfunction

  // register-space responder: answers one cycle after a fresh request
  always @(posedge clk) begin
    if (!rstN) begin
      regDone <= 1'b0;
    end else begin
      regDone <= 1'b0;
      if (regValid && !regDone) begin
        int act;
        int exp;
        act = encReg(regWrite, int'(regAddr), int'(regWdata));
        exp = (regExp.size() > 0) ? regExp.pop_front() : -1;
        check(act == exp, "R3 register access", act, exp);
        regDone <= 1'b1;
        regErr  <= regFault(int'(regAddr));
        if (!regFault(int'(regAddr))) begin
          if (regWrite) regMem[int'(regAddr)] = regWdata;
          regRdata <= regMem.exists(int'(regAddr)) ? regMem[int'(regAddr)] : memInit(int'(regAddr));
        end
      end
    end
  end

  // I2C responder: targets 0x50, 0x51, 0x53; 0x53 refuses reads; byte 0xEE refused on writes
  always @(posedge clk) begin
    if (!rstN) begin
      i2cDone <= 1'b0;
      i2cBusy <= 1'b0;
    end else begin
      i2cDone <= 1'b0;
      if (i2cReqValid && !i2cDone) begin
        int act;
        int exp;
        bit ok;
        ok = 1'b1;
        case (i2cOp)
          2'b00: begin
            act = encI2c(0, i2cRead, int'(i2cAddr));
            ok  = devPresent(int'(i2cAddr));
            if (ok) begin i2cBusy <= 1'b1; devQ <= i2cAddr; end
          end
          2'b01: begin
            act = encI2c(1, i2cRead, i2cRead ? 0 : int'(i2cWrByte));
            if (i2cRead) begin
              ok = (devQ != 7'h53);
              if (ok) begin i2cRdByte <= 8'(8'h30 + rspRdCnt); rspRdCnt++; end
            end else begin
              ok = (i2cWrByte != 8'hEE);
            end
          end
          default: begin
            act = encI2c(2, 1'b0, 0);
            i2cBusy <= 1'b0;
          end
        endcase
        exp = (i2cExp.size() > 0) ? i2cExp.pop_front() : -1;
        check(act == exp, "R5-R9 I2C operation", act, exp);
        i2cDone <= 1'b1;
        i2cAck  <= ok;
      end
    end
  end

  // ---- reference model of the request semantics ----
  bit   mBusy = 1'b0;
  int   mLastAddr = 0;
  int   mLastCmd = 0;
  logic [6:0] mDev = '0;
  int   mRdCnt = 0;

  task automatic runReq(input int cmd, input int addr, input int len,
                        input logic [127:0] wd, input int holdCycles, input string req);
    logic [127:0] expData;
    int expCode;
    bit rd;
    bit ok;
    expData = wd;
    rd = cmd[0];
    expCode = 1;
    if (cmd == 'h8 || cmd == 'h9) begin
      expCode = 0;
      for (int i = 0; i < len; i++) begin
        int a;
        a = (addr + i) & 'hFFFFF;
        regExp.push_back(encReg(!rd, a, int'(wd[i*8 +: 8])));
        if (regFault(a)) begin expCode = 1; break; end
        if (!rd) modelMem[a] = wd[i*8 +: 8];
        else expData[i*8 +: 8] = modelMem.exists(a) ? modelMem[a] : memInit(a);
      end
    end else if (cmd == 'h0 || cmd == 'h1 || cmd == 'h4 || cmd == 'h5) begin
      bit mot;
      bit doStart;
      mot = (cmd >= 4);
      doStart = 1'b1;
      if (!mot) begin
        if (mBusy) begin i2cExp.push_back(encI2c(2, 0, 0)); mBusy = 0; end
      end else if (!mBusy) begin
        doStart = 1'b1;
      end else if (addr == mLastAddr && cmd == mLastCmd) begin
        doStart = 1'b0;
      end else begin
        i2cExp.push_back(encI2c(2, 0, 0));
        mBusy = 0;
      end
      ok = 1'b1;
      if (doStart) begin
        i2cExp.push_back(encI2c(0, rd, addr & 'h7F));
        ok = devPresent(addr & 'h7F);
        if (ok) begin mBusy = 1; mDev = 7'(addr & 'h7F); end
      end
      if (!ok) begin
        expCode = 2;
      end else begin
        if (mot) begin mLastAddr = addr; mLastCmd = cmd; end
        expCode = 0;
        for (int i = 0; i < len; i++) begin
          bit bok;
          i2cExp.push_back(encI2c(1, rd, rd ? 0 : int'(wd[i*8 +: 8])));
          if (rd) begin
            bok = (mDev != 7'h53);
            if (bok) begin expData[i*8 +: 8] = 8'(8'h30 + mRdCnt); mRdCnt++; end
          end else begin
            bok = (wd[i*8 +: 8] != 8'hEE);
          end
          if (!bok) begin expCode = 2; break; end
        end
        if (!mot || expCode != 0) begin
          i2cExp.push_back(encI2c(2, 0, 0));
          mBusy = 0;
        end
      end
    end

    // drive the request
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid  = 1'b1;
    reqCmd    = 4'(cmd);
    reqAddr   = 20'(addr);
    reqLen    = 5'(len);
    reqWrData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R2 not ready after accept", reqReady, 0);
    while (!rspValid) @(negedge clk);
    for (int h = 0; h < holdCycles; h++) begin
      @(negedge clk);
      check(rspValid && reqReady == 1'b0, "R2 reply held", {rspValid, reqReady}, 2);
    end
    check(rspCode == 2'(expCode), {req, " reply code"}, rspCode, expCode);
    if (rd && expCode == 0 && cmd != 'h3 && cmd != 'hB)
      check(rspRdData == expData, {req, " read data"}, rspRdData, expData);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check(regExp.size() == 0 && i2cExp.size() == 0, {req, " all operations seen"},
          regExp.size() + i2cExp.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected reply");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [127:0] wd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0, "R2 reset idle", {reqReady, rspValid}, 2);
    check(regValid == 1'b0 && i2cReqValid == 1'b0, "R10 reset quiet", {regValid, i2cReqValid}, 0);

    wd = 128'h0;
    wd[31:0] = 32'hA1B2C3D4;
    runReq('h8, 'h00100, 4, wd, 0, "R3 native write");
    runReq('h9, 'h00100, 4, 128'h0, 0, "R4 native read back");
    runReq('h9, 'h00200, 16, 128'h0, 2, "R4 native read full length");
    runReq('h9, 'hEFFFE, 4, 128'h0, 0, "R4 native read into fault");
    runReq('h8, 'hEFFFF, 3, wd, 0, "R4 native write into fault");
    runReq('h3, 'h00100, 2, wd, 0, "R1 unknown command");
    runReq('hC, 'h00050, 2, wd, 1, "R1 unknown command high");

    wd = 128'h0;
    wd[23:0] = 24'h332211;
    runReq('h0, 'h00050, 3, wd, 0, "R7 plain write");
    runReq('h0, 'h00020, 3, wd, 0, "R6 plain write absent target");
    wd[23:0] = 24'h33EE11;
    runReq('h0, 'h00051, 3, wd, 0, "R7 plain write refused byte");
    runReq('h1, 'h00050, 4, 128'h0, 0, "R7 plain read");

    wd = 128'h0;
    wd[15:0] = 16'h6655;
    runReq('h4, 'h00050, 2, wd, 0, "R8 open write start");
    runReq('h4, 'h00050, 2, wd, 0, "R8 open write continue");
    runReq('h5, 'h00050, 3, 128'h0, 0, "R8 open read restart on command");
    runReq('h5, 'h00050, 2, 128'h0, 0, "R8 open read continue");
    runReq('h5, 'h00051, 2, 128'h0, 0, "R8 open read restart on address");
    runReq('h1, 'h00050, 2, 128'h0, 0, "R5 plain read stops open transaction");
    runReq('h4, 'h00051, 1, wd, 0, "R9 open write left open");
    runReq('h5, 'h00053, 2, 128'h0, 0, "R9 open read refused byte");
    runReq('h4, 'h00050, 1, wd, 0, "R9 open write after stop");
    runReq('h4, 'h00020, 1, wd, 0, "R6 open restart to absent target");
    runReq('h4, 'h00050, 1, wd, 0, "R8 open start after refusal");
    wd[7:0] = 8'hEE;
    runReq('h4, 'h00050, 2, wd, 0, "R9 open write refused byte");
    runReq('h8, 'h00300, 2, wd, 0, "R3 native after I2C");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule